// File: doc/BRIEF.md
# Multi-Mode Logarithmic Barrel Shifter

This block is a purely combinational shifter for a datapath whose width is a power of two (4, 8, 16 and up). It takes a data word, a shift count of log2(width) bits and a two-bit operation code. In a single evaluation it returns the word shifted or rotated by that count, with no registers on the path.

All four operations go through one multiplexer core that moves data only toward the least significant end. The core has one 2:1 multiplexer stage per bit of the shift count. The stage driven by count bit x moves the word by 2^x positions when that bit is set. The stages run from the smallest step to the largest. A wrap control decides whether bits pushed past the low end are dropped or fed back in at the high end. The two left-hand operations mirror the bit order of the word before the core and mirror the core's output again afterwards. Both directions therefore share the same core.

Top module: `bsh_barrel`

## Requirements
- R1: With `op_i` = 2'b00 (logical right), `result_o` equals `data_i` moved `amt_i` places toward bit 0. Bits leaving bit 0 are lost and the top `amt_i` bits of the result are zero.
- R2: With `op_i` = 2'b01 (logical left), `result_o` equals `data_i` moved `amt_i` places toward the MSB. Bits leaving the MSB are lost and the low `amt_i` bits of the result are zero.
- R3: With `op_i` = 2'b10 (rotate right), result bit i equals `data_i` bit (i + `amt_i`) mod WIDTH.
- R4: With `op_i` = 2'b11 (rotate left), result bit i equals `data_i` bit (i - `amt_i`) mod WIDTH.
- R5: When `amt_i` is zero, `result_o` equals `data_i` for every operation code.
- R6: At the largest count (WIDTH-1), each operation gives its exact result on both the 8-bit and the 16-bit instance. For example, a logical right shift of all-ones data leaves only bit 0 set.
- R7: Both rotations keep every input bit, so the number of ones in `result_o` equals that in `data_i`. A logical shift never increases that number.
- R8: Each count bit x acts on its own as a move of exactly 2^x places, so a count with a single bit set gives that power-of-two move.
- R9: `result_o` depends only on the current inputs and is valid within the same clock period in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to shift or rotate |
| amt_i | input | log2(WIDTH) | Number of bit places to move |
| op_i | input | 2 | Operation: 00 logical right, 01 logical left, 10 rotate right, 11 rotate left |
| result_o | output | WIDTH | Shifted or rotated word |

## Verification
On the 8-bit instance the bench covers every data, count and operation combination. This exposes a stage wired with the wrong step, or a wrap path taken from the wrong bit, because some count or data pattern would then give a wrong word. On the 16-bit instance it uses random vectors plus all-ones data, a lone set bit at the MSB and at bit 0, and the largest count. A design that reversed only one side of the core would return a left result flipped end to end. A design that filled logical shifts from the wrap path would leave ones in the vacated positions. A design with a stray inversion or mux default at count zero would fail the pass-through case. Rotations are also checked for an unchanged count of ones, which catches dropped or duplicated bits.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    // Operation codes; bit 0 picks direction, bit 1 picks wrap-around
    typedef enum logic [1:0] {
        BSH_SRL = 2'b00,
        BSH_SLL = 2'b01,
        BSH_ROR = 2'b10,
        BSH_ROL = 2'b11
    } bsh_op_e;

    // Control word that steers the shared right-moving core
    typedef struct packed {
        logic mirror;   // reverse bit order around the core
        logic wrap;     // feed low-end bits back into the high end
    } bsh_ctrl_t;

    function automatic bsh_ctrl_t bsh_decode(bsh_op_e op);
        bsh_ctrl_t c;
        case (op)
            BSH_SRL: begin c.mirror = 1'b0; c.wrap = 1'b0; end
            BSH_SLL: begin c.mirror = 1'b1; c.wrap = 1'b0; end
            BSH_ROR: begin c.mirror = 1'b0; c.wrap = 1'b1; end
            default: begin c.mirror = 1'b1; c.wrap = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsh_mirror.sv
// Optionally reverses the bit order of a word.
module bsh_mirror #(
    parameter int WIDTH = 8
) (
    input  logic             en_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] flipped;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign flipped[b] = d_i[WIDTH-1-b];
    end

    assign q_o = en_i ? flipped : d_i;
endmodule

// File: rtl/bsh_stage.sv
// One 2:1 mux rank: moves the word STEP places toward bit 0 when enabled.
module bsh_stage #(
    parameter int WIDTH = 8,
    parameter int STEP  = 1
) (
    input  logic             en_i,
    input  logic             wrap_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] moved;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b + STEP < WIDTH) begin : g_inside
            assign moved[b] = d_i[b+STEP];
        end else begin : g_edge
            assign moved[b] = wrap_i & d_i[b+STEP-WIDTH];
        end
    end

    assign q_o = en_i ? moved : d_i;
endmodule

// File: rtl/bsh_core.sv
// Log-depth right-only core: stage s steps by 2^s under count bit s.
module bsh_core #(
    parameter  int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] d_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             wrap_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] lvl [AMT_W+1];

    assign lvl[0] = d_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        bsh_stage #(
            .WIDTH (WIDTH),
            .STEP  (1 << s)
        ) u_stage (
            .en_i   (amt_i[s]),
            .wrap_i (wrap_i),
            .d_i    (lvl[s]),
            .q_o    (lvl[s+1])
        );
    end

    assign q_o = lvl[AMT_W];
endmodule

// File: rtl/bsh_barrel.sv
// Four-operation shifter built around a single right-moving core.
module bsh_barrel
    import bsh_pkg::*;
#(
    parameter  int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o
);
    bsh_ctrl_t        ctrl;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;

    assign ctrl = bsh_decode(bsh_op_e'(op_i));

    bsh_mirror #(.WIDTH(WIDTH)) u_pre (
        .en_i (ctrl.mirror),
        .d_i  (data_i),
        .q_o  (core_in)
    );

    bsh_core #(.WIDTH(WIDTH)) u_core (
        .d_i    (core_in),
        .amt_i  (amt_i),
        .wrap_i (ctrl.wrap),
        .q_o    (core_out)
    );

    bsh_mirror #(.WIDTH(WIDTH)) u_post (
        .en_i (ctrl.mirror),
        .d_i  (core_out),
        .q_o  (result_o)
    );
endmodule

// File: rtl/bsh_barrel_chk.sv
// Port-level checker attached to every bsh_barrel instance.
module bsh_barrel_chk #(
    parameter  int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] data_i,
    input logic [AMT_W-1:0] amt_i,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] result_o
);
    int               cnt;
    logic [WIDTH-1:0] top_part;
    logic [WIDTH-1:0] low_part;

    always_comb begin
        cnt      = int'(amt_i);
        top_part = result_o >> (WIDTH - cnt);
        low_part = result_o << (WIDTH - cnt);

        // R5: zero count passes the word through
        if (cnt == 0) begin
            p_zero_count_pass_r5: assert (result_o == data_i)
                else $error("p_zero_count_pass_r5");
        end
        // R1: vacated top positions are zero
        if (op_i == 2'b00 && cnt != 0) begin
            p_srl_top_zero_r1: assert (top_part == '0)
                else $error("p_srl_top_zero_r1");
        end
        // R2: vacated low positions are zero
        if (op_i == 2'b01 && cnt != 0) begin
            p_sll_low_zero_r2: assert (low_part == '0)
                else $error("p_sll_low_zero_r2");
        end
        // R7: rotations keep the ones count
        if (op_i[1]) begin
            p_rotate_keeps_ones_r7: assert ($countones(result_o) == $countones(data_i))
                else $error("p_rotate_keeps_ones_r7");
        end else begin
            p_shift_no_new_ones_r7: assert ($countones(result_o) <= $countones(data_i))
                else $error("p_shift_no_new_ones_r7");
        end
    end
endmodule

bind bsh_barrel bsh_barrel_chk #(.WIDTH(WIDTH)) u_chk (
    .data_i   (data_i),
    .amt_i    (amt_i),
    .op_i     (op_i),
    .result_o (result_o)
);

// File: tb/tb_bsh_barrel.sv
module tb_bsh_barrel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  d8;  logic [2:0] a8;  logic [1:0] o8;  logic [7:0]  r8;
    logic [15:0] d16; logic [3:0] a16; logic [1:0] o16; logic [15:0] r16;

    bsh_barrel #(.WIDTH(8))  dut     (.data_i(d8),  .amt_i(a8),  .op_i(o8),  .result_o(r8));
    bsh_barrel #(.WIDTH(16)) dut_w16 (.data_i(d16), .amt_i(a16), .op_i(o16), .result_o(r16));

    typedef struct packed {
        logic        wide;
        logic [15:0] din;
        logic [3:0]  amt;
        logic [1:0]  op;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Behavioural model from shift and OR operators
    function automatic logic [15:0] model(int w, logic [15:0] d, int k, logic [1:0] op);
        logic [31:0] x, m, r;
        x = {16'h0, d};
        m = (32'h1 << w) - 1;
        case (op)
            2'b00:   r = x >> k;
            2'b01:   r = (x << k) & m;
            2'b10:   r = ((x >> k) | (x << (w - k))) & m;
            default: r = ((x << k) | (x >> (w - k))) & m;
        endcase
        return r[15:0];
    endfunction

    function automatic string tag(int w, int k, logic [1:0] op);
        if (k == 0) return "R5";
        if (k == w - 1) return "R6";
        if ((k & (k - 1)) == 0) return "R8";
        case (op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic drive8(logic [7:0] d, int k, logic [1:0] op);
        item_t it;
        @(posedge clk);
        d8 = d; a8 = 3'(k); o8 = op;
        it.wide = 1'b0; it.din = {8'h0, d}; it.amt = 4'(k); it.op = op;
        it.exp = model(8, {8'h0, d}, k, op);
        q.push_back(it);
    endtask

    task automatic drive16(logic [15:0] d, int k, logic [1:0] op);
        item_t it;
        @(posedge clk);
        d16 = d; a16 = 4'(k); o16 = op;
        it.wide = 1'b1; it.din = d; it.amt = 4'(k); it.op = op;
        it.exp = model(16, d, k, op);
        q.push_back(it);
    endtask

    // Monitor: sample half a period after the driver (R9: same-period result)
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            int w;
            it  = q.pop_front();
            w   = it.wide ? 16 : 8;
            got = it.wide ? r16 : {8'h0, r8};
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s (R9 same period) w=%0d op=%b amt=%0d din=%h actual=%h expected=%h",
                         tag(w, int'(it.amt), it.op), w, it.op, it.amt, it.din, got, it.exp);
            end
            if (it.op[1]) begin
                total++;
                if ($countones(got) != $countones(it.din)) begin
                    bad++;
                    $display("FAIL R7 ones count actual=%0d expected=%0d",
                             $countones(got), $countones(it.din));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        d8 = '0; a8 = '0; o8 = '0; d16 = '0; a16 = '0; o16 = '0;
        // Idle state: all-zero inputs give zero (R5)
        drive8(8'h00, 0, 2'b00);
        // R1 R2 R3 R4 R5 R6 R8: exhaustive 8-bit sweep
        for (int op = 0; op < 4; op++)
            for (int k = 0; k < 8; k++)
                for (int d = 0; d < 256; d++)
                    drive8(8'(d), k, 2'(op));
        // R6: 16-bit corners at every count, every op
        for (int op = 0; op < 4; op++)
            for (int k = 0; k < 16; k++) begin
                drive16(16'hFFFF, k, 2'(op));
                drive16(16'h8000, k, 2'(op));
                drive16(16'h0001, k, 2'(op));
            end
        // R1 R2 R3 R4: 16-bit random vectors
        for (int i = 0; i < 3000; i++)
            drive16(16'($urandom), int'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule